// File: doc/BRIEF.md
# Page Translation Cache with Global Entries and Selective Invalidation

This block caches recent virtual-page to physical-frame translations so that most address translations skip the page-table walk. A lookup is purely combinational: it presents a virtual page number and gets back, in the same cycle, a hit flag and the cached frame number. When a lookup misses, an external walker reads the page tables and then offers the result on the fill port. If the walked entry was not present, the walker marks the fill as not present. Such a fill is dropped, and the fault is handled outside this block.

The cache does not notice on its own when the page tables in memory change. Software must tell it. A full-flush strobe represents a reload of the page-table base register. It drops every translation except those installed as global, which are kept for mappings that must never move, such as interrupt handlers. A single-page invalidate strobe names one virtual page and drops only that page's translation, even when it is global. All entries live in a small fully associative array. A fill takes the lowest free slot. When no slot is free, it evicts the slot named by a rotating pointer.

Top module: `page_xlate_cache`

## Requirements
- R1: A lookup returns `lk_hit`=1 and the stored frame on `lk_pfn` in the same cycle when a valid entry holds `lk_vpn`. Otherwise `lk_hit`=0 and `lk_pfn`=0.
- R2: A fill with `fill_en`=1 and `fill_present`=1 makes later lookups of `fill_vpn` hit with `fill_pfn`, from the cycle after the fill edge.
- R3: A fill whose page is not yet cached goes to the lowest-numbered invalid slot, and in that case the rotating pointer does not move.
- R4: When all ENTRIES slots are valid, a fill of a new page evicts the slot named by the rotating pointer. The pointer starts at slot 0 after reset and then advances by one, wrapping to 0 after ENTRIES-1.
- R5: A `flush_all` pulse invalidates every entry installed with `fill_glb`=0 and keeps every entry installed with `fill_glb`=1.
- R6: An `inval_en` pulse invalidates only the entry that holds `inval_vpn`, whether or not it is global. Every other entry is untouched.
- R7: A fill with `fill_present`=0 changes no entry and does not move the pointer.
- R8: A fill whose page is already cached overwrites that entry in place, so no page is ever held twice.
- R9: A flush or invalidate does not affect a lookup made in the same cycle. It takes effect at the next clock edge.
- R10: Reset clears every valid bit, including the valid bits of global entries.
- R11: If a fill arrives in the same cycle as a flush or invalidate, the filled entry is valid after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | VPN_W | Virtual page number to look up |
| lk_hit | output | 1 | Lookup found a valid translation |
| lk_pfn | output | PFN_W | Frame number for the hit, 0 on a miss |
| fill_en | input | 1 | Install strobe from the walker |
| fill_present | input | 1 | Walked entry was present; 0 drops the fill |
| fill_vpn | input | VPN_W | Virtual page of the fill |
| fill_pfn | input | PFN_W | Frame number of the fill |
| fill_glb | input | 1 | Install the entry as global |
| flush_all | input | 1 | Base-register reload: drop all non-global entries |
| inval_en | input | 1 | Single-page invalidate strobe |
| inval_vpn | input | VPN_W | Page to invalidate |

## Verification
A valid bit that is left set when it should have been cleared shows up as a stale hit on the next lookup of that page. This is visible one cycle after the flush or invalidate edge. A wrong slot choice or a pointer that did not advance stays hidden until the cache is full. At that point the next fill evicts the wrong page, and a lookup of that page, one cycle later, misses when it should hit or hits when it should miss. A duplicated tag appears as a frame value that is the OR of two frames.

// File: rtl/xc_pkg.sv
package xc_pkg;
  // Where a fill's target slot came from
  typedef enum logic [1:0] {
    SRC_MATCH = 2'd0,
    SRC_FREE  = 2'd1,
    SRC_ROT   = 2'd2
  } victim_src_e;
endpackage

// File: rtl/xc_tag_cmp.sv
module xc_tag_cmp #(
  parameter int N  = 8,
  parameter int VW = 20
) (
  input  logic [VW-1:0] tags  [N],
  input  logic [N-1:0]  valid,
  input  logic [VW-1:0] key,
  output logic [N-1:0]  match
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end
endmodule

// File: rtl/xc_victim.sv
module xc_victim
  import xc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] valid,
  input  logic [N-1:0] fill_match,
  input  logic         fill_do,
  output logic [N-1:0] sel,
  output victim_src_e  src,
  output logic         rot_step
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q;
  logic [N-1:0]  free_vec;
  logic [N-1:0]  free_low;
  logic [N-1:0]  ptr_hot;

  // Isolate the lowest set bit of a vector
  function automatic logic [N-1:0] lowest_one(input logic [N-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  function automatic logic [N-1:0] to_onehot(input logic [IW-1:0] idx);
    logic [N-1:0] r;
    r = '0;
    r[idx] = 1'b1;
    return r;
  endfunction

  function automatic logic [IW-1:0] ptr_next(input logic [IW-1:0] p);
    return (p == IW'(N - 1)) ? '0 : p + 1'b1;
  endfunction

  assign free_vec = ~valid;
  assign free_low = lowest_one(free_vec);
  assign ptr_hot  = to_onehot(ptr_q);

  always_comb begin
    if (|fill_match) begin
      sel = fill_match;
      src = SRC_MATCH;
    end else if (|free_vec) begin
      sel = free_low;
      src = SRC_FREE;
    end else begin
      sel = ptr_hot;
      src = SRC_ROT;
    end
  end

  assign rot_step = fill_do && (src == SRC_ROT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (rot_step) ptr_q <= ptr_next(ptr_q);
  end
endmodule

// File: rtl/xc_store.sv
module xc_store #(
  parameter int N  = 8,
  parameter int VW = 20,
  parameter int PW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  wr_sel,
  input  logic [N-1:0]  clr_sel,
  input  logic [VW-1:0] wr_vpn,
  input  logic [PW-1:0] wr_pfn,
  input  logic          wr_glb,
  output logic [N-1:0]  valid_q,
  output logic [N-1:0]  glb_q,
  output logic [VW-1:0] vpn_q [N],
  output logic [PW-1:0] pfn_q [N]
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    // Valid bit: a write takes priority over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          valid_q[g] <= 1'b0;
      else if (wr_sel[g])  valid_q[g] <= 1'b1;
      else if (clr_sel[g]) valid_q[g] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        glb_q[g] <= 1'b0;
        vpn_q[g] <= '0;
        pfn_q[g] <= '0;
      end else if (wr_sel[g]) begin
        glb_q[g] <= wr_glb;
        vpn_q[g] <= wr_vpn;
        pfn_q[g] <= wr_pfn;
      end
    end
  end
endmodule

// File: rtl/page_xlate_cache.sv
module page_xlate_cache
  import xc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  input  logic             fill_en,
  input  logic             fill_present,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_glb,
  input  logic             flush_all,
  input  logic             inval_en,
  input  logic [VPN_W-1:0] inval_vpn
);
  localparam int N = ENTRIES;

  logic [N-1:0]     valid_q;
  logic [N-1:0]     glb_q;
  logic [VPN_W-1:0] vpn_q [N];
  logic [PFN_W-1:0] pfn_q [N];

  logic [N-1:0] lk_match;
  logic [N-1:0] fill_match;
  logic [N-1:0] inval_match;
  logic [N-1:0] victim_sel;
  logic [N-1:0] wr_sel;
  logic [N-1:0] clr_sel;
  logic         fill_do;
  logic         rot_step;
  victim_src_e  victim_src;

  // OR-combine the frames of the matching slots (at most one)
  function automatic logic [PFN_W-1:0] pick_pfn(input logic [N-1:0] m,
                                                input logic [PFN_W-1:0] f [N]);
    logic [PFN_W-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) if (m[i]) r |= f[i];
    return r;
  endfunction

  xc_tag_cmp #(.N(N), .VW(VPN_W)) u_cmp_lk (
    .tags(vpn_q), .valid(valid_q), .key(lk_vpn), .match(lk_match));
  xc_tag_cmp #(.N(N), .VW(VPN_W)) u_cmp_fill (
    .tags(vpn_q), .valid(valid_q), .key(fill_vpn), .match(fill_match));
  xc_tag_cmp #(.N(N), .VW(VPN_W)) u_cmp_inval (
    .tags(vpn_q), .valid(valid_q), .key(inval_vpn), .match(inval_match));

  assign fill_do = fill_en && fill_present;

  xc_victim #(.N(N)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid(valid_q), .fill_match(fill_match),
    .fill_do(fill_do), .sel(victim_sel), .src(victim_src), .rot_step(rot_step));

  assign wr_sel  = fill_do ? victim_sel : '0;
  assign clr_sel = ({N{flush_all}} & ~glb_q) | ({N{inval_en}} & inval_match);

  xc_store #(.N(N), .VW(VPN_W), .PW(PFN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .clr_sel(clr_sel),
    .wr_vpn(fill_vpn), .wr_pfn(fill_pfn), .wr_glb(fill_glb),
    .valid_q(valid_q), .glb_q(glb_q), .vpn_q(vpn_q), .pfn_q(pfn_q));

  assign lk_hit = |lk_match;
  assign lk_pfn = pick_pfn(lk_match, pfn_q);
endmodule

// File: rtl/xc_checker.sv
module xc_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         flush_all,
  input logic         inval_en,
  input logic         fill_en,
  input logic         fill_present,
  input logic         rot_step,
  input logic [N-1:0] valid_q,
  input logic [N-1:0] glb_q,
  input logic [N-1:0] lk_match,
  input logic [N-1:0] fill_match,
  input logic [N-1:0] inval_match
);
  AST_FLUSH_DROPS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !fill_en) |=> ((valid_q & ~glb_q) == '0)); // R5
  AST_FLUSH_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !fill_en && !inval_en) |=> (valid_q == $past(valid_q & glb_q))); // R5
  AST_INVAL_ONLY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_en && !flush_all && !fill_en) |=> (valid_q == $past(valid_q & ~inval_match))); // R6
  AST_ABSENT_FILL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !fill_present && !flush_all && !inval_en) |=> $stable(valid_q)); // R7
  AST_NO_DUP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match) && $onehot0(fill_match)); // R8
  AST_ROT_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rot_step |-> ($countones(valid_q) == N)); // R4
endmodule

bind page_xlate_cache xc_checker #(.N(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_all(flush_all), .inval_en(inval_en),
  .fill_en(fill_en), .fill_present(fill_present), .rot_step(rot_step),
  .valid_q(valid_q), .glb_q(glb_q), .lk_match(lk_match),
  .fill_match(fill_match), .inval_match(inval_match));

// File: tb/page_xlate_cache_tb.sv
`timescale 1ns/1ps
module page_xlate_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic        lk_hit;
  logic [19:0] lk_pfn;
  logic        fill_en = 1'b0, fill_present = 1'b0, fill_glb = 1'b0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic        flush_all = 1'b0, inval_en = 1'b0;
  logic [19:0] inval_vpn = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        exp_hit_q [$];
  logic [19:0] exp_pfn_q [$];
  string       exp_req_q [$];
  event        sample_ev;

  always #2.5 clk = ~clk;

  page_xlate_cache u_dut (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
    .fill_en(fill_en), .fill_present(fill_present), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_glb(fill_glb), .flush_all(flush_all),
    .inval_en(inval_en), .inval_vpn(inval_vpn));

  // Monitor: pops one expected item per sample event and compares
  always @(sample_ev) begin
    logic        eh;
    logic [19:0] ep;
    string       rq;
    eh = exp_hit_q.pop_front();
    ep = exp_pfn_q.pop_front();
    rq = exp_req_q.pop_front();
    checks++;
    if (lk_hit !== eh || lk_pfn !== ep) begin
      errors++;
      $display("FAIL %s vpn=%h: hit=%b pfn=%h expected hit=%b pfn=%h",
               rq, lk_vpn, lk_hit, lk_pfn, eh, ep);
    end
  end

  // Driver: one cycle per call, entered and left at a falling edge
  task automatic cyc(input bit fe, input bit fp, input logic [19:0] fv,
                     input logic [19:0] fpf, input bit fg, input bit fl,
                     input bit ie, input logic [19:0] iv,
                     input bit lk, input logic [19:0] lv,
                     input bit eh, input logic [19:0] ep, input string rq);
    fill_en = fe; fill_present = fp; fill_vpn = fv; fill_pfn = fpf; fill_glb = fg;
    flush_all = fl; inval_en = ie; inval_vpn = iv; lk_vpn = lv;
    if (lk) begin
      exp_hit_q.push_back(eh);
      exp_pfn_q.push_back(eh ? ep : 20'h0);
      exp_req_q.push_back(rq);
      #1 ->sample_ev;
    end
    @(negedge clk);
    fill_en = 0; flush_all = 0; inval_en = 0;
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p, input bit g);
    cyc(1, 1, v, p, g, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic look(input logic [19:0] v, input bit eh, input logic [19:0] ep,
                      input string rq);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, v, eh, ep, rq);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    look(20'h00010, 0, 0, "R10 reset empty");

    fill(20'h00010, 20'h00100, 0);
    look(20'h00010, 1, 20'h00100, "R1 R2 hit after fill");
    look(20'h00011, 0, 0, "R1 miss other page");
    cyc(1, 0, 20'h00011, 20'h00777, 0, 0, 0, 0, 0, 0, 0, 0, "");
    look(20'h00011, 0, 0, "R7 not-present fill dropped");
    fill(20'h00010, 20'h00200, 0);
    look(20'h00010, 1, 20'h00200, "R8 refill overwrites in place");

    // slots 1..7: 0x20(global) 0x21..0x26
    fill(20'h00020, 20'h01020, 1);
    for (int i = 1; i < 7; i++) fill(20'h00020 + i, 20'h01020 + i, 0);
    look(20'h00026, 1, 20'h01026, "R2 last slot filled");
    look(20'h00010, 1, 20'h00200, "R8 refill kept one slot");

    fill(20'h00030, 20'h03030, 0);            // evicts slot0, ptr->1
    look(20'h00010, 0, 0, "R4 pointer evicts slot 0");
    look(20'h00030, 1, 20'h03030, "R4 new entry");
    fill(20'h00031, 20'h03031, 0);            // evicts slot1, ptr->2
    look(20'h00020, 0, 0, "R4 pointer advanced to slot 1");
    look(20'h00021, 1, 20'h01021, "R4 slot 2 kept");

    cyc(0, 0, 0, 0, 0, 0, 1, 20'h00023, 0, 0, 0, 0, "");
    look(20'h00023, 0, 0, "R6 invalidated page gone");
    look(20'h00024, 1, 20'h01024, "R6 neighbour untouched");
    fill(20'h00020, 20'h02020, 1);            // hole at slot4, ptr stays 2
    fill(20'h00032, 20'h03032, 0);            // evicts slot2 (0x21)
    look(20'h00021, 0, 0, "R3 free-slot fill did not move pointer");
    look(20'h00022, 1, 20'h01022, "R3 slot 3 kept");
    look(20'h00020, 1, 20'h02020, "R3 hole filled");

    cyc(0, 0, 0, 0, 0, 1, 0, 0, 1, 20'h00024, 1, 20'h01024, "R9 lookup beside flush");
    look(20'h00024, 0, 0, "R5 local dropped by flush");
    look(20'h00030, 0, 0, "R5 local dropped by flush");
    look(20'h00020, 1, 20'h02020, "R5 global survives flush");
    cyc(0, 0, 0, 0, 0, 0, 1, 20'h00020, 1, 20'h00020, 1, 20'h02020, "R9 lookup beside invalidate");
    look(20'h00020, 0, 0, "R6 global invalidated");

    cyc(1, 1, 20'h00040, 20'h04040, 0, 1, 1, 20'h00040, 0, 0, 0, 0, "");
    look(20'h00040, 1, 20'h04040, "R11 fill wins over flush");

    fill(20'h00050, 20'h05050, 1);
    look(20'h00050, 1, 20'h05050, "R2 global fill");
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    look(20'h00050, 0, 0, "R10 reset clears global");
    look(20'h00040, 0, 0, "R10 reset clears local");

    done = 1;
    report();
  end
endmodule